// File: doc/BRIEF.md
# Up/Down Counter Register Field

This block is one storage field of a memory-mapped control/status register. Its width is a parameter. Hardware increment and decrement pulses move it up or down by one. Software may overwrite it at any time. Elaboration parameters decide, separately for each direction, what happens at the range limit:

- A saturating direction clips at the limit and raises a level indication while it sits there.
- A wrapping direction rolls over modulo 2^W and pulses an event for the single cycle in which the wrap is requested.

Threshold comparators report when the value is at or above an upper mark, or at or below a lower mark. A mark of zero is a valid setting and is not the same as leaving the comparator out. An optional parity bit is recomputed on every load and compared against the stored value.

Each cycle the field works out a candidate next value and a load enable, and the storage register takes the candidate only when the load enable is set. A build with `HAS_RESET` = 0 has no reset path at all: `rst_ni` is then ignored and the field is never reset.

The enclosing register block owns address decoding and read-back. It drives the write strobe and data, and uses `value_o` and the indication outputs.

Default build: 8 bits, upward counting wraps, downward counting saturates, upper threshold 200, lower threshold 0, reset value 0x05, parity on.

Top module: `cnt_field`

## Requirements
- R1: With `HAS_RESET`=1, `value_o` equals `RESET_VAL` (default 0x05) while `rst_ni` is low and after its release until the field is next loaded.
- R2: When `sw_we_i` is high at a rising edge, `value_o` takes `sw_wdata_i` at that edge, whatever `incr_i` and `decr_i` are. In that cycle no overflow or underflow event is raised.
- R3: With `sw_we_i` low, a cycle with only `incr_i` high adds 1 and a cycle with only `decr_i` high subtracts 1. A cycle with both high or both low leaves `value_o` unchanged.
- R4: In a wrapping upward build (default), an increment at all ones loads 0. `overflow_o` is high combinationally in exactly the cycle in which that wrapping increment is presented, and low in every other cycle.
- R5: In a saturating downward build (default), a decrement at 0 leaves the value at 0. `decr_sat_o` is high exactly while `value_o` is 0.
- R6: Each direction offers either its saturate indication or its wrap event, never both. In the default build `incr_sat_o` and `underflow_o` are constantly 0.
- R7: `incr_thr_o` is high exactly when `value_o >= INCR_THR` (default 200).
- R8: `decr_thr_o` is high exactly when `value_o <= DECR_THR`. The default mark of 0 is a configured threshold, so the output is high only at value 0.
- R9: With `HAS_PARITY`=1, an even-parity bit is stored with every load. `parity_err_o` is high only when the stored bit disagrees with the stored value, so it stays low in fault-free operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (ignored when `HAS_RESET`=0) |
| sw_we_i | input | 1 | Software write strobe for the field |
| sw_wdata_i | input | W | Software write data |
| incr_i | input | 1 | Hardware increment pulse |
| decr_i | input | 1 | Hardware decrement pulse |
| value_o | output | W | Stored field value |
| incr_thr_o | output | 1 | Value at or above the upper threshold |
| decr_thr_o | output | 1 | Value at or below the lower threshold |
| incr_sat_o | output | 1 | Upward saturating build: value is at all ones |
| overflow_o | output | 1 | Upward wrapping build: wrap requested this cycle |
| decr_sat_o | output | 1 | Downward saturating build: value is at zero |
| underflow_o | output | 1 | Downward wrapping build: wrap requested this cycle |
| parity_err_o | output | 1 | Stored parity disagrees with stored value |

## Verification
The hardest situation to reach is a limit event that meets other inputs in the same cycle: an increment at all ones that collides with a software write or with a simultaneous decrement, where the event must be suppressed. Random increments alone would take hundreds of cycles to climb to the limit. The stimulus therefore biases write data towards 0x00, 0xFF and the threshold neighbours 199 and 200, and then mixes random increment, decrement and write pulses so that collisions at the limits occur often. Directed steps cover the exact wrap, the clip at zero and the threshold boundaries.

// File: rtl/cnt_field_pkg.sv
package cnt_field_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DN   = 2'd2,
    ACT_WR   = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/cnt_field_next.sv
module cnt_field_next
  import cnt_field_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter bit          HAS_INCR = 1'b1,
  parameter bit          HAS_DECR = 1'b1,
  parameter bit          INCR_SAT = 1'b0,
  parameter bit          DECR_SAT = 1'b1
) (
  input  logic [W-1:0] cur_i,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_wdata_i,
  input  logic         incr_i,
  input  logic         decr_i,
  output logic [W-1:0] next_o,
  output logic         load_o,
  output logic         wrap_up_o,
  output logic         wrap_dn_o
);
  localparam logic [W-1:0] MAX_V = '1;
  localparam logic [W-1:0] ONE_V = W'(1);

  cnt_act_e act;
  logic up, dn, at_max, at_min;

  assign up     = HAS_INCR & incr_i;
  assign dn     = HAS_DECR & decr_i;
  assign at_max = (cur_i == MAX_V);
  assign at_min = (cur_i == '0);

  always_comb begin
    if (sw_we_i)        act = ACT_WR;
    else if (up && !dn) act = ACT_UP;
    else if (dn && !up) act = ACT_DN;
    else                act = ACT_HOLD;
  end

  always_comb begin
    next_o    = cur_i;
    load_o    = 1'b0;
    wrap_up_o = 1'b0;
    wrap_dn_o = 1'b0;
    unique case (act)
      ACT_WR: begin
        next_o = sw_wdata_i;
        load_o = 1'b1;
      end
      ACT_UP: begin
        // saturating build: no load at the limit
        if (!(INCR_SAT && at_max)) begin
          next_o    = cur_i + ONE_V;
          load_o    = 1'b1;
          wrap_up_o = at_max;
        end
      end
      ACT_DN: begin
        if (!(DECR_SAT && at_min)) begin
          next_o    = cur_i - ONE_V;
          load_o    = 1'b1;
          wrap_dn_o = at_min;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cnt_field_store.sv
module cnt_field_store #(
  parameter int unsigned W          = 8,
  parameter bit          HAS_RESET  = 1'b1,
  parameter logic [W-1:0] RESET_VAL = '0,
  parameter bit          HAS_PARITY = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] next_i,
  input  logic         load_i,
  output logic [W-1:0] value_o,
  output logic         parity_err_o
);
  localparam logic RESET_PAR = ^RESET_VAL;

  logic [W-1:0] value_q;
  logic         par_q;

  if (HAS_RESET) begin : g_rst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     value_q <= RESET_VAL;
      else if (load_i) value_q <= next_i;
    end
  end else begin : g_norst
    // no reset value configured: the field is never reset
    logic unused_rst;
    assign unused_rst = rst_ni;
    always_ff @(posedge clk_i) begin
      if (load_i) value_q <= next_i;
    end
  end

  if (HAS_PARITY) begin : g_par
    if (HAS_RESET) begin : g_par_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     par_q <= RESET_PAR;
        else if (load_i) par_q <= ^next_i;
      end
    end else begin : g_par_norst
      always_ff @(posedge clk_i) begin
        if (load_i) par_q <= ^next_i;
      end
    end
    assign parity_err_o = par_q ^ (^value_q);
  end else begin : g_nopar
    assign par_q        = 1'b0;
    assign parity_err_o = 1'b0;
  end

  assign value_o = value_q;
endmodule

// File: rtl/cnt_field_flags.sv
module cnt_field_flags #(
  parameter int unsigned W            = 8,
  parameter bit          HAS_INCR     = 1'b1,
  parameter bit          HAS_DECR     = 1'b1,
  parameter bit          INCR_SAT     = 1'b0,
  parameter bit          DECR_SAT     = 1'b1,
  parameter bit          HAS_INCR_THR = 1'b1,
  parameter logic [W-1:0] INCR_THR    = '1,
  parameter bit          HAS_DECR_THR = 1'b1,
  parameter logic [W-1:0] DECR_THR    = '0
) (
  input  logic [W-1:0] value_i,
  input  logic         wrap_up_i,
  input  logic         wrap_dn_i,
  output logic         incr_thr_o,
  output logic         decr_thr_o,
  output logic         incr_sat_o,
  output logic         overflow_o,
  output logic         decr_sat_o,
  output logic         underflow_o
);
  localparam logic [W-1:0] MAX_V = '1;

  if (HAS_INCR && HAS_INCR_THR) begin : g_ithr
    assign incr_thr_o = (value_i >= INCR_THR);
  end else begin : g_noithr
    assign incr_thr_o = 1'b0;
  end

  if (HAS_DECR && HAS_DECR_THR) begin : g_dthr
    assign decr_thr_o = (value_i <= DECR_THR);
  end else begin : g_nodthr
    assign decr_thr_o = 1'b0;
  end

  // exactly one limit output per direction
  if (HAS_INCR && INCR_SAT) begin : g_isat
    assign incr_sat_o = (value_i == MAX_V);
    assign overflow_o = 1'b0;
  end else if (HAS_INCR) begin : g_iwrap
    assign incr_sat_o = 1'b0;
    assign overflow_o = wrap_up_i;
  end else begin : g_noinc
    assign incr_sat_o = 1'b0;
    assign overflow_o = 1'b0;
  end

  if (HAS_DECR && DECR_SAT) begin : g_dsat
    assign decr_sat_o  = (value_i == '0);
    assign underflow_o = 1'b0;
  end else if (HAS_DECR) begin : g_dwrap
    assign decr_sat_o  = 1'b0;
    assign underflow_o = wrap_dn_i;
  end else begin : g_nodec
    assign decr_sat_o  = 1'b0;
    assign underflow_o = 1'b0;
  end
endmodule

// File: rtl/cnt_field.sv
module cnt_field #(
  parameter int unsigned W            = 8,
  parameter bit          HAS_INCR     = 1'b1,
  parameter bit          HAS_DECR     = 1'b1,
  parameter bit          INCR_SAT     = 1'b0,
  parameter bit          DECR_SAT     = 1'b1,
  parameter bit          HAS_INCR_THR = 1'b1,
  parameter logic [W-1:0] INCR_THR    = W'(200),
  parameter bit          HAS_DECR_THR = 1'b1,
  parameter logic [W-1:0] DECR_THR    = '0,
  parameter bit          HAS_RESET    = 1'b1,
  parameter logic [W-1:0] RESET_VAL   = W'(5),
  parameter bit          HAS_PARITY   = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_wdata_i,
  input  logic         incr_i,
  input  logic         decr_i,
  output logic [W-1:0] value_o,
  output logic         incr_thr_o,
  output logic         decr_thr_o,
  output logic         incr_sat_o,
  output logic         overflow_o,
  output logic         decr_sat_o,
  output logic         underflow_o,
  output logic         parity_err_o
);
  logic [W-1:0] next_val;
  logic         load;
  logic         wrap_up, wrap_dn;

  cnt_field_next #(
    .W(W), .HAS_INCR(HAS_INCR), .HAS_DECR(HAS_DECR),
    .INCR_SAT(INCR_SAT), .DECR_SAT(DECR_SAT)
  ) u_next (
    .cur_i(value_o), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .incr_i(incr_i), .decr_i(decr_i),
    .next_o(next_val), .load_o(load),
    .wrap_up_o(wrap_up), .wrap_dn_o(wrap_dn)
  );

  cnt_field_store #(
    .W(W), .HAS_RESET(HAS_RESET), .RESET_VAL(RESET_VAL), .HAS_PARITY(HAS_PARITY)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .next_i(next_val), .load_i(load),
    .value_o(value_o), .parity_err_o(parity_err_o)
  );

  cnt_field_flags #(
    .W(W), .HAS_INCR(HAS_INCR), .HAS_DECR(HAS_DECR),
    .INCR_SAT(INCR_SAT), .DECR_SAT(DECR_SAT),
    .HAS_INCR_THR(HAS_INCR_THR), .INCR_THR(INCR_THR),
    .HAS_DECR_THR(HAS_DECR_THR), .DECR_THR(DECR_THR)
  ) u_flags (
    .value_i(value_o), .wrap_up_i(wrap_up), .wrap_dn_i(wrap_dn),
    .incr_thr_o(incr_thr_o), .decr_thr_o(decr_thr_o),
    .incr_sat_o(incr_sat_o), .overflow_o(overflow_o),
    .decr_sat_o(decr_sat_o), .underflow_o(underflow_o)
  );
endmodule

// File: rtl/cnt_field_chk.sv
module cnt_field_chk #(
  parameter int unsigned W        = 8,
  parameter bit          INCR_SAT = 1'b0,
  parameter bit          DECR_SAT = 1'b1,
  parameter bit          HAS_RESET = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sw_we_i,
  input logic [W-1:0] sw_wdata_i,
  input logic         incr_i,
  input logic         decr_i,
  input logic [W-1:0] value_o,
  input logic         incr_sat_o,
  input logic         overflow_o,
  input logic         decr_sat_o,
  input logic         underflow_o,
  input logic         parity_err_o
);
  logic rst_gate;
  assign rst_gate = HAS_RESET && !rst_ni;

  p_swwr_r2: assert property (@(posedge clk_i) disable iff (rst_gate)
    sw_we_i |=> value_o == $past(sw_wdata_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_gate)
    (!sw_we_i && (incr_i == decr_i)) |=> $stable(value_o));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_gate)
    overflow_o |=> value_o == '0);

  p_no_ovf_wr_r2: assert property (@(posedge clk_i) disable iff (rst_gate)
    sw_we_i |-> !overflow_o && !underflow_o);

  p_clip_r5: assert property (@(posedge clk_i) disable iff (rst_gate)
    (DECR_SAT && !sw_we_i && decr_i && !incr_i && value_o == '0) |=> value_o == '0);

  p_one_kind_r6: assert property (@(posedge clk_i) disable iff (rst_gate)
    !(incr_sat_o && overflow_o) && !(decr_sat_o && underflow_o));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (rst_gate)
    INCR_SAT |-> !overflow_o);

  p_parity_r9: assert property (@(posedge clk_i) disable iff (rst_gate)
    !parity_err_o);
endmodule

bind cnt_field cnt_field_chk #(
  .W(W), .INCR_SAT(INCR_SAT), .DECR_SAT(DECR_SAT), .HAS_RESET(HAS_RESET)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
  .incr_i(incr_i), .decr_i(decr_i), .value_o(value_o),
  .incr_sat_o(incr_sat_o), .overflow_o(overflow_o),
  .decr_sat_o(decr_sat_o), .underflow_o(underflow_o),
  .parity_err_o(parity_err_o)
);

// File: tb/tb_cnt_field.sv
`timescale 1ns/1ps
module tb_cnt_field;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sw_we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         incr = 1'b0, decr = 1'b0;
  logic [W-1:0] value;
  logic incr_thr, decr_thr, incr_sat, overflow, decr_sat, underflow, par_err;

  int checks = 0, fails = 0;
  logic [W-1:0] mdl;

  always #4 clk = ~clk;

  cnt_field dut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_we_i(sw_we), .sw_wdata_i(wdata),
    .incr_i(incr), .decr_i(decr), .value_o(value),
    .incr_thr_o(incr_thr), .decr_thr_o(decr_thr), .incr_sat_o(incr_sat),
    .overflow_o(overflow), .decr_sat_o(decr_sat), .underflow_o(underflow),
    .parity_err_o(par_err)
  );

  function automatic logic [W-1:0] f_next(logic [W-1:0] v, logic we, logic [W-1:0] wd,
                                          logic inc, logic dec);
    if (we) return wd;
    if (inc && !dec) return v + 8'd1;
    if (dec && !inc) return (v == 0) ? v : v - 8'd1;
    return v;
  endfunction

  function automatic logic f_ovf(logic [W-1:0] v, logic we, logic inc, logic dec);
    return !we && inc && !dec && v == 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags();
    chk("R7 incr_thr", incr_thr, mdl >= 200);
    chk("R8 decr_thr", decr_thr, mdl == 0);
    chk("R5 decr_sat", decr_sat, mdl == 0);
    chk("R6 incr_sat", incr_sat, 0);
    chk("R6 underflow", underflow, 0);
    chk("R9 parity", par_err, 0);
  endtask

  task automatic step(logic we, logic [W-1:0] wd, logic inc, logic dec);
    @(negedge clk);
    sw_we = we; wdata = wd; incr = inc; decr = dec;
    #1;
    chk(we ? "R2 overflow" : "R4 overflow", overflow, f_ovf(mdl, we, inc, dec));
    chk_flags();
    mdl = f_next(mdl, we, wd, inc, dec);
    @(posedge clk);
    #1;
    chk(we ? "R2 value" : "R3 value", value, mdl);
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset value", value, 8'h05);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", value, 8'h05);
    mdl = 8'h05;

    // R3 basic up/down/both
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    // R4 wrap at all ones
    step(1, 8'hFF, 0, 0);
    step(0, 0, 1, 0);
    chk("R4 wrapped to zero", value, 0);
    // R2 write beats increment at the limit
    step(1, 8'hFF, 0, 0);
    step(1, 8'h42, 1, 0);
    step(1, 8'hFF, 0, 0);
    step(0, 0, 1, 1);
    // R5 clip at zero
    step(1, 8'h00, 0, 0);
    step(0, 0, 0, 1);
    chk("R5 held at zero", value, 0);
    step(0, 0, 0, 1);
    // R7 boundaries 199 / 200
    step(1, 8'd199, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    // R8 at 1 then 0
    step(1, 8'd1, 0, 0);
    step(0, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [W-1:0] wd;
      sel = $urandom_range(0, 7);
      case (sel)
        0: wd = 8'h00;
        1: wd = 8'hFF;
        2: wd = 8'd199;
        3: wd = 8'd200;
        4: wd = 8'hFE;
        5: wd = 8'h01;
        default: wd = 8'($urandom);
      endcase
      step(($urandom_range(0, 9) == 0), wd, 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule